// File: doc/BRIEF.md
# Partitioned Sub-Word SIMD Adder

This block is a 64-bit adder whose internal carry chain can be cut at byte boundaries. A two-bit lane-width mode selects whether the word is handled as one 64-bit addition, two 32-bit additions, four 16-bit additions or eight 8-bit additions. All lanes share one operation select, addition or subtraction, and are computed in the same cycle.

The datapath is built from byte-wide slices. A control decoder turns the mode and the operation select into per-slice strobes. One strobe marks the slices that begin a lane: at these the carry from below is dropped and the subtract carry-in is injected. Another strobe marks the slices that end a lane: at these the carry-out is reported. The packed result and the per-lane carry flags are captured in a register. They appear one clock after the operands.

Top module: `lane_split_adder`

## Requirements
- R1: With laneMode = 2'b11 the block performs one 64-bit operation: sumOut = opA + opB modulo 2^64 (addition), and laneCarry[7] holds the carry out of bit 63.
- R2: With laneMode = 2'b10 the word is two independent 32-bit lanes (bits 31:0 and 63:32), each wrapping modulo 2^32.
- R3: With laneMode = 2'b01 the word is four independent 16-bit lanes, each wrapping modulo 2^16.
- R4: With laneMode = 2'b00 the word is eight independent 8-bit lanes, each wrapping modulo 2^8.
- R5: In every mode no carry crosses a lane boundary. A lane that overflows leaves the lane above it unchanged from its own lane-local sum.
- R6: With subSel = 1 every active lane computes opA - opB modulo the lane width. This is done by adding the inverted opB and a carry-in of 1 at the lane's lowest bit. The lane's carry flag is then the carry out of that sum (1 means no borrow).
- R7: The carry-out of a lane appears on laneCarry bit k, where k is the index of the lane's most significant byte (byte k holds bits 8k+7:8k). All other laneCarry bits read 0.
- R8: Outputs are registered. sumOut and laneCarry reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R9: While rstN is low, sumOut and laneCarry are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 64 | First operand, packed lanes |
| opB | input | 64 | Second operand, packed lanes |
| laneMode | input | 2 | 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = 64-bit lanes |
| subSel | input | 1 | 0 = add, 1 = subtract in every lane |
| sumOut | output | 64 | Registered packed result |
| laneCarry | output | 8 | Registered per-lane carry-out at each lane's top byte |

## Verification
Two functions can act in one cycle: carry-in injection for subtraction at a lane's base, and carry suppression at the same boundary when the lane below overflows. The bench provokes this with all-ones minuends and zero subtrahends, and with 0xFF-patterned sums, in every mode. It judges each lane against a lane-wise reference that never chains bytes. Random operands are biased toward all-ones lanes so that boundary carries are frequent, and the mode changes on every cycle. This also tests that one operation never leaks into the next.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int SLICE_W     = 8;
  localparam int SLICE_COUNT = 8;
  localparam int DATA_W      = SLICE_W * SLICE_COUNT;
  localparam int MODE_W      = 2;
  localparam int IDX_W       = $clog2(SLICE_COUNT);

  typedef enum logic [MODE_W-1:0] {
    LANE8  = 2'b00,
    LANE16 = 2'b01,
    LANE32 = 2'b10,
    LANE64 = 2'b11
  } laneMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                   invertB;    // subtract: invert B, inject carry 1
    logic [SLICE_COUNT-1:0] laneStart;  // slice is the lowest slice of a lane
    logic [SLICE_COUNT-1:0] laneTop;    // slice is the highest slice of a lane
  } sliceCtrl_t;
endpackage

// File: rtl/lsa_ctrl.sv
module lsa_ctrl
  import lsa_pkg::*;
(
  input  logic [MODE_W-1:0] laneMode,
  input  logic              subSel,
  output sliceCtrl_t        ctrl
);
  logic [IDX_W-1:0]       posMask;
  logic [SLICE_COUNT-1:0] startVec;
  logic [SLICE_COUNT-1:0] topVec;

  // Bits of the slice index that select a position inside one lane
  always_comb begin
    unique case (laneMode)
      LANE8:   posMask = 3'b000;
      LANE16:  posMask = 3'b001;
      LANE32:  posMask = 3'b011;
      default: posMask = 3'b111;
    endcase
  end

  for (genvar i = 0; i < SLICE_COUNT; i++) begin : g_slice_dec
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    assign startVec[i] = (IDX & posMask) == '0;
    assign topVec[i]   = (IDX & posMask) == posMask;
  end

  always_comb begin
    ctrl.invertB   = subSel;
    ctrl.laneStart = startVec;
    ctrl.laneTop   = topVec;
  end
endmodule

// File: rtl/lsa_datapath.sv
module lsa_datapath
  import lsa_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [DATA_W-1:0]      opA,
  input  logic [DATA_W-1:0]      opB,
  input  sliceCtrl_t             ctrl,
  output logic [DATA_W-1:0]      sumOut,
  output logic [SLICE_COUNT-1:0] laneCarry
);
  logic [DATA_W-1:0]      sumNext;
  logic [SLICE_COUNT-1:0] carryNext;

  // Byte slices chained through a carry that is killed at lane starts
  always_comb begin
    logic             chainCarry;
    logic             sliceIn;
    logic [SLICE_W-1:0] aSlice;
    logic [SLICE_W-1:0] bSlice;
    logic [SLICE_W:0]   partial;
    chainCarry = 1'b0;
    sumNext    = '0;
    carryNext  = '0;
    for (int i = 0; i < SLICE_COUNT; i++) begin
      aSlice  = opA[i*SLICE_W +: SLICE_W];
      bSlice  = opB[i*SLICE_W +: SLICE_W] ^ {SLICE_W{ctrl.invertB}};
      sliceIn = ctrl.laneStart[i] ? ctrl.invertB : chainCarry;
      partial = {1'b0, aSlice} + {1'b0, bSlice} + {{SLICE_W{1'b0}}, sliceIn};
      sumNext[i*SLICE_W +: SLICE_W] = partial[SLICE_W-1:0];
      carryNext[i] = ctrl.laneTop[i] & partial[SLICE_W];
      chainCarry   = partial[SLICE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumOut    <= '0;
      laneCarry <= '0;
    end else begin
      sumOut    <= sumNext;
      laneCarry <= carryNext;
    end
  end
endmodule

// File: rtl/lane_split_adder.sv
module lane_split_adder
  import lsa_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [DATA_W-1:0]      opA,
  input  logic [DATA_W-1:0]      opB,
  input  logic [MODE_W-1:0]      laneMode,
  input  logic                   subSel,
  output logic [DATA_W-1:0]      sumOut,
  output logic [SLICE_COUNT-1:0] laneCarry
);
  sliceCtrl_t ctrl;

  lsa_ctrl u_ctrl (
    .laneMode (laneMode),
    .subSel   (subSel),
    .ctrl     (ctrl)
  );

  lsa_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .opA       (opA),
    .opB       (opB),
    .ctrl      (ctrl),
    .sumOut    (sumOut),
    .laneCarry (laneCarry)
  );
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker
  import lsa_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic [DATA_W-1:0]      opA,
  input logic [DATA_W-1:0]      opB,
  input logic [MODE_W-1:0]      laneMode,
  input logic                   subSel,
  input logic [DATA_W-1:0]      sumOut,
  input logic [SLICE_COUNT-1:0] laneCarry
);
  logic [DATA_W-1:0]      bEff;
  logic [DATA_W:0]        fullRef;
  logic [SLICE_W:0]       byte0Ref;
  logic [SLICE_W:0]       byte1Ref;
  logic [SLICE_COUNT-1:0] topMask;

  assign bEff     = subSel ? ~opB : opB;
  assign fullRef  = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, subSel};
  assign byte0Ref = {1'b0, opA[7:0]} + {1'b0, bEff[7:0]} + {8'd0, subSel};
  assign byte1Ref = {1'b0, opA[15:8]} + {1'b0, bEff[15:8]} + {8'd0, subSel};

  always_comb begin
    unique case (laneMode)
      2'b00:   topMask = 8'hFF;
      2'b01:   topMask = 8'hAA;
      2'b10:   topMask = 8'h88;
      default: topMask = 8'h80;
    endcase
  end

  // R1: full-width mode, result and top carry one cycle later
  p_full_width_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(laneMode) == 2'b11) |-> ({laneCarry[7], sumOut} == $past(fullRef)));

  // R6: lowest byte always begins a lane, so it is a lane-local add/subtract
  p_low_byte_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (sumOut[7:0] == $past(byte0Ref[7:0])));

  // R5: in byte mode byte 1 sees no carry from byte 0
  p_no_cross_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(laneMode) == 2'b00) |-> (sumOut[15:8] == $past(byte1Ref[7:0])));

  // R7: flags outside lane-top positions stay 0
  p_flag_pos_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((laneCarry & ~$past(topMask)) == 8'h00));

  // R8: output only moves at a clock edge following an input change
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && $stable(opA) && $stable(opB) && $stable(laneMode)
     && $stable(subSel)) |=> $stable(sumOut));
endmodule

bind lane_split_adder lsa_checker u_lsa_checker (
  .clk       (clk),
  .rstN      (rstN),
  .opA       (opA),
  .opB       (opB),
  .laneMode  (laneMode),
  .subSel    (subSel),
  .sumOut    (sumOut),
  .laneCarry (laneCarry)
);

// File: tb/lane_split_adder_bench.sv
`timescale 1ns/1ps
module lane_split_adder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [1:0]  laneMode = 2'b00;
  logic        subSel = 1'b0;
  logic [63:0] sumOut;
  logic [7:0]  laneCarry;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lane_split_adder u_lane_split_adder (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB),
    .laneMode(laneMode), .subSel(subSel),
    .sumOut(sumOut), .laneCarry(laneCarry)
  );

  // Lane-wise reference: each lane computed on its own, no byte chaining
  task automatic refCalc(input logic [63:0] a, input logic [63:0] b,
                         input logic [1:0] m, input logic s,
                         output logic [63:0] res, output logic [7:0] fl);
    int w;
    int lanes;
    logic [64:0] mask;
    logic [64:0] aL;
    logic [64:0] bL;
    logic [64:0] tot;
    w = 8 << m;
    lanes = 64 / w;
    mask = (65'd1 << w) - 65'd1;
    res = '0;
    fl = '0;
    for (int l = 0; l < lanes; l++) begin
      aL = ({1'b0, a} >> (l * w)) & mask;
      bL = ({1'b0, b} >> (l * w)) & mask;
      if (s) bL = ~bL & mask;
      tot = aL + bL + {64'd0, s};
      res = res | 64'((tot & mask) << (l * w));
      fl[(l * w) / 8 + w / 8 - 1] = tot[w];
    end
  endtask

  function automatic string modeTag(input logic [1:0] m, input logic s);
    if (s) return "R6";
    case (m)
      2'b00: return "R4";
      2'b01: return "R3";
      2'b10: return "R2";
      default: return "R1";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [63:0] expRes, input logic [7:0] expFl);
    checks++;
    if (sumOut !== expRes) begin
      failures++;
      $display("FAIL %s sumOut actual=%h expected=%h", tag, sumOut, expRes);
    end
    checks++;
    if (laneCarry !== expFl) begin
      failures++;
      $display("FAIL R7 (%s) laneCarry actual=%b expected=%b", tag, laneCarry, expFl);
    end
  endtask

  // Called at a negedge: drive, wait one cycle, check
  task automatic step(input logic [63:0] a, input logic [63:0] b,
                      input logic [1:0] m, input logic s, input string tag);
    logic [63:0] er;
    logic [7:0]  ef;
    refCalc(a, b, m, s, er, ef);
    opA = a; opB = b; laneMode = m; subSel = s;
    @(negedge clk);
    compare(tag, er, ef);
  endtask

  function automatic logic [63:0] laneBias(input logic [63:0] v, input logic [1:0] m);
    logic [63:0] r;
    int w;
    w = 8 << m;
    r = v;
    for (int l = 0; l < 64 / w; l++)
      if ($urandom_range(0, 2) == 0)
        for (int k = 0; k < w; k++) r[l * w + k] = 1'b1;
    return r;
  endfunction

  initial begin
    logic [63:0] er;
    logic [7:0]  ef;
    void'($urandom(32'h1D5A_7C03));
    // R9: reset holds outputs at zero even with live inputs
    opA = 64'hFFFF_FFFF_FFFF_FFFF; opB = 64'h1; laneMode = 2'b11;
    repeat (3) @(negedge clk);
    compare("R9", 64'd0, 8'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 full-width add with a carry rippling across all bytes
    step(64'h0000_0000_0000_00FF, 64'h1, 2'b11, 1'b0, "R1");
    step(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'b11, 1'b0, "R1");
    // R5: same operands in narrower modes, carries stop at lane edges
    step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 1'b0, "R5");
    step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 2'b01, 1'b0, "R5");
    step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'b10, 1'b0, "R5");
    step(64'h80FF_7F00_FF80_01FE, 64'h8001_0101_0180_FF02, 2'b00, 1'b0, "R4");
    step(64'h1234_FFFF_8000_0001, 64'h0001_0001_8000_FFFF, 2'b01, 1'b0, "R3");
    step(64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'b10, 1'b0, "R2");
    // R6: subtraction, carry injection coinciding with boundary kill
    step(64'h0, 64'h0101_0101_0101_0101, 2'b00, 1'b1, "R6");
    step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'b01, 1'b1, "R6");
    step(64'h0000_0000_0000_0000, 64'h0, 2'b10, 1'b1, "R6");
    step(64'h1, 64'h2, 2'b11, 1'b1, "R6");

    // R8: output unchanged right after inputs change, before the edge
    refCalc(64'h55, 64'h11, 2'b00, 1'b0, er, ef);
    opA = 64'h55; opB = 64'h11; laneMode = 2'b00; subSel = 1'b0;
    @(negedge clk);
    opA = 64'hAA; opB = 64'h22;
    #1;
    compare("R8", er, ef);
    @(negedge clk);
    refCalc(64'hAA, 64'h22, 2'b00, 1'b0, er, ef);
    compare("R8", er, ef);

    // Random stimulus, mode and operation changing every cycle
    for (int n = 0; n < 600; n++) begin
      logic [1:0]  m;
      logic        s;
      logic [63:0] a;
      logic [63:0] b;
      m = 2'($urandom_range(0, 3));
      s = 1'($urandom_range(0, 1));
      a = laneBias({$urandom, $urandom}, m);
      b = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) b = s ? 64'd0 : 64'h0101_0101_0101_0101;
      step(a, b, m, s, modeTag(m, s));
    end

    // R9: reset asserted mid-run clears the outputs
    rstN = 1'b0;
    #1;
    compare("R9", 64'd0, 8'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule